// File: doc/BRIEF.md
# Synchronized PRF Trigger Generator with Echo Time Capture

This block produces one pulse-repetition-frequency trigger and drives it onto six identical outputs, so that every radar subsystem it feeds starts its transmit pulse on the same clock edge. The repetition interval and the pulse width are both given in clock cycles. The interval is held between the cycle counts that correspond to 7 kHz and 500 Hz at the configured clock rate. Any change to the interval or to the width is applied only when the next pulse starts, so a pulse that is already under way is never cut short or stretched by a settings change.

Each subsystem returns an echo trigger. The block brings every echo input into its own clock domain, detects the rising edge and stores a record for that channel. The record holds the local time, taken from a time-service bus, and the sequence number of the most recent trigger pulse. The record stays valid until the consumer acknowledges it. If a new echo arrives while a record is still unread, the new echo replaces it and an overflow flag is set for that channel.

Top module: `prf_sync_gen`

## Requirements
- R1: While reset is held and right after it is released, all trigger outputs, record-valid flags and overflow flags are 0.
- R2: The requested interval is clamped to the range [CLK_HZ/7000, CLK_HZ/500] cycles. Pulses start every clamped-interval cycles. The first pulse starts in the cycle after the first clock edge at which `run` is seen high.
- R3: Each pulse stays high for exactly W cycles, where W is the requested width clamped to the range 1 to (interval − 1).
- R4: All NUM_CH trigger outputs carry the same value in every cycle.
- R5: A change to the interval or width request made while `run` is high takes effect only at the start of the next pulse.
- R6: The pulse count goes up by one when each pulse starts, so the first pulse after `run` rises is number 1. While `run` is low the count is 0 and all trigger outputs are low.
- R7: The record-valid flag is set at the third clock edge after a rising edge on an echo input. The record then holds the `time_now` value and the pulse count from the cycle just before that edge. An echo input that stays high produces one capture only.
- R8: A record stays valid until its acknowledge bit is seen high at a clock edge. That edge clears both valid and overflow, unless a new capture happens at the same edge.
- R9: A capture on a channel whose record is still valid and not being acknowledged sets that channel's overflow flag and replaces the record with the newer data.
- R10: Channels are independent. An echo or acknowledge on one channel does not change another channel's flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Generator enable; low stops the triggers and clears the pulse count |
| period_cyc | input | CNT_W | Requested repetition interval in clock cycles |
| width_cyc | input | CNT_W | Requested pulse width in clock cycles |
| time_now | input | TIME_W | Local time from the time-service block |
| prf_out | output | NUM_CH | Trigger outputs, all identical |
| echo_in | input | NUM_CH | Asynchronous echo trigger inputs |
| echo_ack | input | NUM_CH | Per-channel record acknowledge |
| rec_valid | output | NUM_CH | Per-channel record valid |
| rec_ovf | output | NUM_CH | Per-channel overflow flag |
| rec_time | output | NUM_CH*TIME_W | Captured times, channel i at bits [i*TIME_W +: TIME_W] |
| rec_count | output | NUM_CH*SEQ_W | Captured pulse counts, channel i at bits [i*SEQ_W +: SEQ_W] |

## Verification
The trigger outputs are checked in every cycle of a sweep over seven requested intervals and five requested widths. The sweep includes values below the minimum, exactly at both limits and above the maximum, and widths of zero, one and at least the interval. This separates clamping faults from faults in the interval counter and from width off-by-one errors. A run with the interval and width changed partway through a period shows whether a change is applied early. Echo tests are run while the generator is idle and while it is running, with a single echo on each channel in turn, with two echoes and no acknowledge in between, and with an echo held high. These cases separate the capture latency, the overflow rule, edge-versus-level detection and isolation between channels.

// File: rtl/prf_pkg.sv
// Package: shared limits and helpers for the PRF trigger generator.
// Assumes the clock rate is an exact or rounded-down integer in Hz.
package prf_pkg;
    localparam int PRF_LOW_HZ  = 500;
    localparam int PRF_HIGH_HZ = 7000;

    // Clock cycles in one period of the given repetition rate.
    function automatic int cycles_per(input int clk_hz, input int rate_hz);
        return clk_hz / rate_hz;
    endfunction
endpackage

// File: rtl/prf_timer.sv
// prf_timer: interval counter that produces the trigger pulse and the pulse count.
// Assumes P_MIN >= 2, so that a width of at least one cycle leaves a low gap.
// Settings are sampled only at a pulse start. Dropping run ends the current pulse.
module prf_timer #(
    parameter int CNT_W = 18,
    parameter int SEQ_W = 16,
    parameter int P_MIN = 14285,
    parameter int P_MAX = 200000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] period_req,
    input  logic [CNT_W-1:0] width_req,
    output logic             pulse,
    output logic [SEQ_W-1:0] seq
);
    localparam logic [CNT_W-1:0] LO = CNT_W'(P_MIN);
    localparam logic [CNT_W-1:0] HI = CNT_W'(P_MAX);

    logic             run_q;
    logic [CNT_W-1:0] phase, per_cur, wid_cur, per_new, wid_new;
    logic             start;

    // Clamp the requested interval and width into their legal ranges.
    always_comb begin
        if (period_req < LO)      per_new = LO;
        else if (period_req > HI) per_new = HI;
        else                      per_new = period_req;
        if (width_req == '0)           wid_new = CNT_W'(1);
        else if (width_req >= per_new) wid_new = per_new - CNT_W'(1);
        else                           wid_new = width_req;
    end

    assign start = !run_q || (phase == per_cur - CNT_W'(1));

    // Advance the phase; at each pulse start load new settings and count the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            phase   <= '0;
            per_cur <= LO;
            wid_cur <= CNT_W'(1);
            seq     <= '0;
        end else if (!run) begin
            run_q <= 1'b0;
            phase <= '0;
            seq   <= '0;
        end else if (start) begin
            run_q   <= 1'b1;
            phase   <= '0;
            per_cur <= per_new;
            wid_cur <= wid_new;
            seq     <= seq + SEQ_W'(1);
        end else begin
            phase <= phase + CNT_W'(1);
        end
    end

    assign pulse = run_q && (phase < wid_cur);
endmodule

// File: rtl/echo_sync.sv
// echo_sync: two-flop synchronizer for one asynchronous echo line, plus a rising-edge detector.
// The rise output is high for one cycle, two edges after the input goes high.
module echo_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [2:0] stage;

    // Shift the input through the synchronizer and the edge-history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) stage <= '0;
        else        stage <= {stage[1:0], async_in};
    end

    assign rise = stage[1] & ~stage[2];
endmodule

// File: rtl/echo_slot.sv
// echo_slot: per-channel record holding the captured time and pulse count.
// A new capture always wins over a pending acknowledge at the same edge.
module echo_slot #(
    parameter int TIME_W = 32,
    parameter int SEQ_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              ack,
    input  logic [TIME_W-1:0] time_now,
    input  logic [SEQ_W-1:0]  seq_now,
    output logic              valid,
    output logic              ovf,
    output logic [TIME_W-1:0] time_q,
    output logic [SEQ_W-1:0]  seq_q
);
    // Capture on an echo edge, flag an overwrite of an unread record, clear on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            ovf    <= 1'b0;
            time_q <= '0;
            seq_q  <= '0;
        end else if (rise) begin
            valid  <= 1'b1;
            ovf    <= valid & ~ack;
            time_q <= time_now;
            seq_q  <= seq_now;
        end else if (ack) begin
            valid <= 1'b0;
            ovf   <= 1'b0;
        end
    end
endmodule

// File: rtl/prf_sync_gen.sv
// prf_sync_gen: programmable PRF trigger driven onto NUM_CH identical outputs,
// with one echo capture record per channel.
// Assumes time_now is synchronous to clk. Echo inputs may be asynchronous.
module prf_sync_gen #(
    parameter int CLK_HZ = 100_000_000,
    parameter int NUM_CH = 6,
    parameter int TIME_W = 32,
    parameter int SEQ_W  = 16,
    localparam int P_MIN = prf_pkg::cycles_per(CLK_HZ, prf_pkg::PRF_HIGH_HZ),
    localparam int P_MAX = prf_pkg::cycles_per(CLK_HZ, prf_pkg::PRF_LOW_HZ),
    localparam int CNT_W = $clog2(P_MAX + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic [CNT_W-1:0]         period_cyc,
    input  logic [CNT_W-1:0]         width_cyc,
    input  logic [TIME_W-1:0]        time_now,
    output logic [NUM_CH-1:0]        prf_out,
    input  logic [NUM_CH-1:0]        echo_in,
    input  logic [NUM_CH-1:0]        echo_ack,
    output logic [NUM_CH-1:0]        rec_valid,
    output logic [NUM_CH-1:0]        rec_ovf,
    output logic [NUM_CH*TIME_W-1:0] rec_time,
    output logic [NUM_CH*SEQ_W-1:0]  rec_count
);
    logic             pulse;
    logic [SEQ_W-1:0] seq;

    prf_timer #(.CNT_W(CNT_W), .SEQ_W(SEQ_W), .P_MIN(P_MIN), .P_MAX(P_MAX)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run),
        .period_req(period_cyc), .width_req(width_cyc),
        .pulse(pulse), .seq(seq)
    );

    // One trigger source drives every output, so all subsystems fire together.
    assign prf_out = {NUM_CH{pulse}};

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic rise;
        echo_sync u_sync (.clk(clk), .rst_n(rst_n), .async_in(echo_in[ch]), .rise(rise));
        echo_slot #(.TIME_W(TIME_W), .SEQ_W(SEQ_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .rise(rise), .ack(echo_ack[ch]),
            .time_now(time_now), .seq_now(seq),
            .valid(rec_valid[ch]), .ovf(rec_ovf[ch]),
            .time_q(rec_time[ch*TIME_W +: TIME_W]),
            .seq_q(rec_count[ch*SEQ_W +: SEQ_W])
        );
    end
endmodule

// File: rtl/prf_sync_gen_chk.sv
// prf_sync_gen_chk: temporal properties of the PRF generator, observed at its ports.
module prf_sync_gen_chk #(
    parameter int NUM_CH = 6,
    parameter int P_MAX  = 200000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic [NUM_CH-1:0] prf_out,
    input logic [NUM_CH-1:0] echo_ack,
    input logic [NUM_CH-1:0] rec_valid,
    input logic [NUM_CH-1:0] rec_ovf
);
    localparam int HW = $clog2(P_MAX + 1) + 1;
    logic [HW-1:0] high_run;

    // Count the consecutive high cycles already seen on trigger output 0.
    always_ff @(posedge clk) begin
        if (!rst_n)          high_run <= '0;
        else if (prf_out[0]) high_run <= high_run + HW'(1);
        else                 high_run <= '0;
    end

    assert_width_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        prf_out[0] |-> (high_run <= HW'(P_MAX - 2)));

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (prf_out == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_p
        assert_valid_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (rec_valid[i] && !echo_ack[i]) |=> rec_valid[i]);
        assert_ovf_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
            rec_ovf[i] |-> rec_valid[i]);
        assert_ovf_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rec_ovf[i]) |-> $past(rec_valid[i]));
    end
endmodule

bind prf_sync_gen prf_sync_gen_chk #(.NUM_CH(NUM_CH), .P_MAX(P_MAX)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .prf_out(prf_out),
    .echo_ack(echo_ack), .rec_valid(rec_valid), .rec_ovf(rec_ovf)
);

// File: tb/prf_sync_gen_tb.sv
module prf_sync_gen_tb;
    localparam int CLK_HZ = 70000;
    localparam int NUM_CH = 6;
    localparam int TIME_W = 32;
    localparam int SEQ_W  = 16;
    localparam int P_MIN  = 10;
    localparam int P_MAX  = 140;
    localparam int CW     = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic [CW-1:0] period_cyc = 8'd20, width_cyc = 8'd5;
    logic [TIME_W-1:0] tcnt = '0;
    logic [NUM_CH-1:0] prf_out, echo_in = '0, echo_ack = '0, rec_valid, rec_ovf;
    logic [NUM_CH*TIME_W-1:0] rec_time;
    logic [NUM_CH*SEQ_W-1:0]  rec_count;

    int checks = 0, fails = 0;
    bit chk_prf = 1'b0;
    bit m_act = 1'b0;
    int m_left = 0, m_high = 0, m_seq = 0;

    always #5 clk = ~clk;
    always @(posedge clk) tcnt <= tcnt + 1;

    prf_sync_gen #(.CLK_HZ(CLK_HZ), .NUM_CH(NUM_CH), .TIME_W(TIME_W), .SEQ_W(SEQ_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .period_cyc(period_cyc), .width_cyc(width_cyc),
        .time_now(tcnt), .prf_out(prf_out), .echo_in(echo_in), .echo_ack(echo_ack),
        .rec_valid(rec_valid), .rec_ovf(rec_ovf), .rec_time(rec_time), .rec_count(rec_count)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int clamp_p(input int p);
        return (p < P_MIN) ? P_MIN : ((p > P_MAX) ? P_MAX : p);
    endfunction

    function automatic int clamp_w(input int w, input int p);
        return (w == 0) ? 1 : ((w >= p) ? p - 1 : w);
    endfunction

    // One cycle: advance the expected schedule using the inputs seen at this edge, then compare.
    task automatic step();
        bit on;
        @(negedge clk);
        if (!run) begin
            m_act = 1'b0; m_left = 0; m_high = 0; m_seq = 0;
        end else if (!m_act || m_left == 1) begin
            m_act = 1'b1; m_left = clamp_p(int'(period_cyc));
            m_high = clamp_w(int'(width_cyc), m_left); m_seq++;
        end else begin
            m_left--; if (m_high > 0) m_high--;
        end
        on = m_act && (m_high > 0);
        if (chk_prf)
            check(prf_out === (on ? {NUM_CH{1'b1}} : {NUM_CH{1'b0}}), "R2/R3/R4/R5 trigger level",
                  longint'(prf_out), on ? longint'({NUM_CH{1'b1}}) : 0);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // Raise echo on a channel, follow it through the synchronizer, check the captured record.
    task automatic fire(input int ch, input bit exp_ovf, input string req);
        longint exp_t, exp_c;
        bit v0;
        echo_in[ch] = 1'b1;
        v0 = rec_valid[ch];
        step(); step();
        exp_t = tcnt; exp_c = m_seq;
        check(rec_valid[ch] === v0, {req, " R7 no early capture"}, rec_valid[ch], v0);
        step();
        check(rec_valid[ch] === 1'b1, {req, " R7 valid on third edge"}, rec_valid[ch], 1);
        check(rec_time[ch*TIME_W +: TIME_W] == exp_t, {req, " R7 captured time"},
              rec_time[ch*TIME_W +: TIME_W], exp_t);
        check(rec_count[ch*SEQ_W +: SEQ_W] == exp_c, {req, " R7 captured count"},
              rec_count[ch*SEQ_W +: SEQ_W], exp_c);
        check(rec_ovf[ch] === exp_ovf, {req, " R9 overflow flag"}, rec_ovf[ch], exp_ovf);
        echo_in[ch] = 1'b0;
    endtask

    task automatic ack(input int ch);
        echo_ack[ch] = 1'b1;
        step();
        echo_ack[ch] = 1'b0;
        check(rec_valid[ch] === 1'b0 && rec_ovf[ch] === 1'b0, "R8 acknowledge clears",
              {rec_valid[ch], rec_ovf[ch]}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int plist[7] = '{3, 10, 11, 17, 25, 140, 200};
        int wlist[5] = '{0, 1, 3, 9, 200};
        steps(3);
        check(prf_out === '0 && rec_valid === '0 && rec_ovf === '0, "R1 in reset",
              {prf_out, rec_valid, rec_ovf}, 0);
        rst_n = 1'b1;
        step();
        check(prf_out === '0 && rec_valid === '0 && rec_ovf === '0, "R1 after reset",
              {prf_out, rec_valid, rec_ovf}, 0);
        chk_prf = 1'b1;

        // R2 R3 R4 sweep over the requested interval and width
        foreach (plist[pi]) foreach (wlist[wi]) begin
            run = 1'b0; steps(2);
            period_cyc = CW'(plist[pi]); width_cyc = CW'(wlist[wi]);
            run = 1'b1;
            steps(3 * clamp_p(plist[pi]) + 2);
        end

        // R5 settings changed partway through a period
        run = 1'b0; steps(2);
        period_cyc = 8'd20; width_cyc = 8'd5; run = 1'b1;
        steps(25);
        period_cyc = 8'd30; width_cyc = 8'd12;
        steps(4);
        period_cyc = 8'd13; width_cyc = 8'd2;
        steps(90);

        // R6 idle: outputs low, echo captures count 0
        run = 1'b0; steps(3);
        fire(0, 1'b0, "R6 idle count");
        ack(0);

        // R6 count restarts at 1; R7 captures during running
        period_cyc = 8'd12; width_cyc = 8'd4; run = 1'b1;
        fire(1, 1'b0, "R6 first pulse");
        check(rec_count[1*SEQ_W +: SEQ_W] == 1, "R6 first pulse is number 1",
              rec_count[1*SEQ_W +: SEQ_W], 1);
        ack(1);
        steps(37);
        fire(1, 1'b0, "R6 later pulse");
        ack(1);

        // R10 each channel alone
        for (int ch = 0; ch < NUM_CH; ch++) begin
            fire(ch, 1'b0, "R10 single channel");
            check(rec_valid === (NUM_CH'(1) << ch), "R10 other channels untouched",
                  rec_valid, NUM_CH'(1) << ch);
            ack(ch);
            check(rec_valid === '0, "R10 acknowledge isolated", rec_valid, 0);
            steps(ch + 3);
        end

        // R9 second echo without acknowledge overwrites and flags
        fire(2, 1'b0, "R9 first echo");
        steps(7);
        fire(2, 1'b1, "R9 second echo");
        steps(5);
        check(rec_valid[2] === 1'b1 && rec_ovf[2] === 1'b1, "R8 record held until acknowledge",
              {rec_valid[2], rec_ovf[2]}, 3);
        ack(2);

        // R7 echo held high captures once
        fire(4, 1'b0, "R7 held echo");
        echo_in[4] = 1'b1;
        ack(4);
        steps(10);
        check(rec_valid[4] === 1'b0, "R7 level does not recapture", rec_valid[4], 0);
        echo_in[4] = 1'b0;
        steps(4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule